// File: doc/BRIEF.md
# SHA-256 Hash Engine with Hardware Length Counting

This block computes the SHA-256 digest of a message that software streams in through a small 32-bit write port. Software opens a message with a start command, writes the message as big-endian 32-bit words, and closes it with a process command. The block never needs the message length from software: it counts the accepted bytes itself, and on the process command it builds the SHA-256 padding (marker byte, zero fill, 64-bit bit count), runs the last compression, and raises an interrupt once the 256-bit digest can be read.

Message words gather in a 16-word block buffer. When the buffer is full and the compression core is idle, the block is handed to the core in one cycle and the buffer is free again, so software can fill the next block while the current one is being compressed. A ready output tells software when a data write will be taken. No key is involved: the same byte sequence always yields the same digest.

The digest is read as eight 32-bit words through a word index. The final word of a message may carry one to four bytes, selected by a byte strobe.

Top module: `sha256_autolen`

## Requirements
- R1: After reset irq is 0, wr_ready is 0, and rd_idx 0..7 read the SHA-256 initial hash words 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19.
- R2: A command write (bus_wr=1, bus_wsel=0) with bus_wdata bit 0 set opens a new message: irq drops, the hash restarts from the initial words, the byte count returns to zero, any message in progress is abandoned, and wr_ready is 1 on the next cycle; bit 0 wins over bit 1 in the same write.
- R3: Data writes (bus_wr=1, bus_wsel=1) made while no message is open, before the first start or after a digest is complete, have no effect on any later digest.
- R4: An accepted data write appends as many bytes as bus_wstrb has set bits, taken from the most significant end of bus_wdata (bits 31:24 first); the digest equals SHA-256 of the appended byte sequence.
- R5: On the process command the block appends byte 0x80, zero bytes and the 64-bit big-endian bit count, using one extra block when the byte length modulo 64 is 56 or more.
- R6: irq rises only after the final block has been added into the hash, and then irq stays 1 and the digest stays constant until the next start command.
- R7: The bit count is measured by the block; a process command with no data written yields the digest of the empty message.
- R8: The buffer takes 16 words per block and wr_ready is 0 while it is full; each block takes 65 cycles from being loaded into the core to the core's done pulse (64 rounds and one add cycle).
- R9: A process command (bus_wdata bit 1 set, bit 0 clear) with no message open is ignored; after a process command wr_ready is 0 and data writes are ignored.
- R10: A data write of fewer than four bytes ends the data of the message; later data writes are ignored until the process command.
- R11: rd_idx selects the digest word combinationally; index 0 is the most significant word of the digest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wsel | input | 1 | 0 selects the command register, 1 the message data port |
| bus_wdata | input | 32 | Write data; command bit 0 = start, bit 1 = process |
| bus_wstrb | input | 4 | Byte strobe for data writes; count of set bits is the byte count |
| rd_idx | input | 3 | Digest word index |
| rd_data | output | 32 | Selected digest word |
| wr_ready | output | 1 | A data write in this cycle will be accepted |
| irq | output | 1 | Digest complete, held until the next start |

## Verification
The bound checker watches, on every cycle, that irq only rises after a core done pulse and then holds together with a frozen digest, that a start command clears irq and reopens the data port, that a full buffer or a finished message keeps wr_ready low, and that each block spends exactly 65 cycles in the core. Whether the padding, byte ordering, partial last word and length counting produce the right digest can only be shown by the bench's scenarios, which compare read-back digests against published vectors and an independent byte-level model across lengths around the 56- and 64-byte block boundaries. The ignore rules for early, late and post-tail writes are likewise shown by scenarios whose final digest would change if such a write slipped in.

// File: rtl/sha256_eng_pkg.sv
package sha256_eng_pkg;

    localparam int WORD_W     = 32;
    localparam int BLK_WORDS  = 16;
    localparam int HASH_WORDS = 8;
    localparam int ROUNDS     = 64;
    localparam int LEN_W      = 64;
    localparam int BYTES_PW   = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wvars_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_LEN,
        PH_LAST
    } phase_e;

    typedef enum logic [1:0] {
        BOP_NONE,
        BOP_MARK,
        BOP_SEND,
        BOP_SEND_LEN
    } buf_op_e;

    localparam word_t H_INIT [HASH_WORDS] = '{
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    localparam word_t K_TAB [ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_s0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_s1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    // One compression round; kw is the round constant plus the schedule word.
    function automatic wvars_t sha_round(input wvars_t v, input word_t kw);
        wvars_t r;
        word_t  t1;
        word_t  t2;
        t1  = v.h + big_s1(v.e) + ((v.e & v.f) ^ (~v.e & v.g)) + kw;
        t2  = big_s0(v.a) + ((v.a & v.b) ^ (v.a & v.c) ^ (v.b & v.c));
        r.h = v.g;
        r.g = v.f;
        r.f = v.e;
        r.e = v.d + t1;
        r.d = v.c;
        r.c = v.b;
        r.b = v.a;
        r.a = t1 + t2;
        return r;
    endfunction

endpackage

// File: rtl/sha256_len_ctr.sv
module sha256_len_ctr
    import sha256_eng_pkg::*;
#(
    parameter int LW  = LEN_W,
    parameter int NBW = $clog2(BYTES_PW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add_en,
    input  logic [NBW-1:0] add_bytes,
    output logic [LW-1:0] len_bits
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            len_bits <= '0;
        end else if (add_en) begin
            len_bits <= len_bits + LW'({add_bytes, 3'b000});
        end
    end

endmodule

// File: rtl/sha256_msg_buf.sv
module sha256_msg_buf
    import sha256_eng_pkg::*;
#(
    parameter int NWORDS = BLK_WORDS,
    parameter int WW     = WORD_W,
    parameter int LW     = LEN_W,
    parameter int BPW    = WW / 8,
    parameter int NBW    = $clog2(BPW + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [WW-1:0]      wr_data,
    input  logic [NBW-1:0]     wr_nbytes,
    input  buf_op_e            op,
    input  logic [LW-1:0]      len_bits,
    output logic               full,
    output logic               tail,
    output logic               fit_len,
    output logic [NWORDS*WW-1:0] blk_out
);

    localparam int PW        = $clog2(NWORDS + 1);
    localparam int IW        = $clog2(NWORDS);
    localparam int BW        = $clog2(BPW);
    localparam int LEN_WORDS = LW / WW;
    localparam int LEN_BASE  = NWORDS - LEN_WORDS;

    logic [WW-1:0] mem [NWORDS];
    logic [PW-1:0] wptr;
    logic [BW-1:0] bcnt;

    logic [IW-1:0] widx;
    logic [IW-1:0] midx;
    logic [WW-1:0] wr_mask;
    logic [WW-1:0] mark_bits;

    assign widx    = wptr[IW-1:0];
    assign full    = (wptr == PW'(NWORDS));
    assign tail    = (bcnt != '0);
    assign fit_len = (wptr <= PW'(LEN_BASE));

    // Bytes are kept from the most significant end; the rest stay zero.
    assign wr_mask   = {WW{1'b1}} << (8 * (BPW - int'(wr_nbytes)));
    // Marker byte sits right after the last message byte.
    assign mark_bits = WW'(8'h80) << (8 * (BPW - 1 - int'(bcnt)));
    assign midx      = tail ? (widx - IW'(1)) : widx;

    always_ff @(posedge clk) begin
        if (rst || clear || op == BOP_SEND || op == BOP_SEND_LEN) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= '0;
            end
            wptr <= '0;
            bcnt <= '0;
        end else if (op == BOP_MARK) begin
            mem[midx] <= mem[midx] | mark_bits;
            if (!tail) begin
                wptr <= wptr + PW'(1);
            end
            bcnt <= '0;
        end else if (wr_en) begin
            mem[widx] <= wr_data & wr_mask;
            wptr      <= wptr + PW'(1);
            bcnt      <= BW'(wr_nbytes);
        end
    end

    generate
        for (genvar i = 0; i < NWORDS; i++) begin : g_out
            if (i >= LEN_BASE) begin : g_lenslot
                localparam int J = i - LEN_BASE;
                assign blk_out[(NWORDS-1-i)*WW +: WW] =
                    (op == BOP_SEND_LEN) ? len_bits[LW-1-J*WW -: WW] : mem[i];
            end else begin : g_plain
                assign blk_out[(NWORDS-1-i)*WW +: WW] = mem[i];
            end
        end
    endgenerate

endmodule

// File: rtl/sha256_round_core.sv
module sha256_round_core
    import sha256_eng_pkg::*;
#(
    parameter int NWORDS  = BLK_WORDS,
    parameter int NROUNDS = ROUNDS,
    parameter int NHASH   = HASH_WORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init,
    input  logic                     load,
    input  logic [NWORDS*WORD_W-1:0] blk,
    output logic                     busy,
    output logic                     done,
    output logic [NHASH*WORD_W-1:0]  hash
);

    localparam int RW = $clog2(NROUNDS);
    localparam logic [RW-1:0] LAST_R = RW'(NROUNDS - 1);

    typedef enum logic [1:0] {
        C_IDLE,
        C_RND,
        C_FIN
    } cst_e;

    cst_e          cst;
    word_t         sched [NWORDS];
    wvars_t        v;
    word_t         hst [NHASH];
    logic [RW-1:0] rcnt;

    word_t  nxt_w;
    wvars_t v_next;
    logic [NHASH*WORD_W-1:0] v_flat;

    assign nxt_w  = small_s1(sched[NWORDS-2]) + sched[NWORDS-7]
                  + small_s0(sched[1]) + sched[0];
    assign v_next = sha_round(v, K_TAB[rcnt] + sched[0]);
    assign v_flat = v;
    assign busy   = (cst != C_IDLE);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cst  <= C_IDLE;
            done <= 1'b0;
            rcnt <= '0;
            v    <= '0;
            for (int i = 0; i < NHASH; i++) begin
                hst[i] <= H_INIT[i];
            end
            for (int i = 0; i < NWORDS; i++) begin
                sched[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (cst)
                C_IDLE: begin
                    if (load) begin
                        for (int i = 0; i < NWORDS; i++) begin
                            sched[i] <= blk[(NWORDS-1-i)*WORD_W +: WORD_W];
                        end
                        v    <= {hst[0], hst[1], hst[2], hst[3],
                                 hst[4], hst[5], hst[6], hst[7]};
                        rcnt <= '0;
                        cst  <= C_RND;
                    end
                end
                C_RND: begin
                    v <= v_next;
                    for (int i = 0; i < NWORDS - 1; i++) begin
                        sched[i] <= sched[i+1];
                    end
                    sched[NWORDS-1] <= nxt_w;
                    rcnt <= rcnt + RW'(1);
                    if (rcnt == LAST_R) begin
                        cst <= C_FIN;
                    end
                end
                C_FIN: begin
                    for (int i = 0; i < NHASH; i++) begin
                        hst[i] <= hst[i] + v_flat[(NHASH-1-i)*WORD_W +: WORD_W];
                    end
                    done <= 1'b1;
                    cst  <= C_IDLE;
                end
                default: cst <= C_IDLE;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NHASH; i++) begin : g_hash
            assign hash[(NHASH-1-i)*WORD_W +: WORD_W] = hst[i];
        end
    endgenerate

endmodule

// File: rtl/sha256_autolen.sv
module sha256_autolen
    import sha256_eng_pkg::*;
#(
    parameter int DW  = WORD_W,
    parameter int SW  = DW / 8,
    parameter int IXW = $clog2(HASH_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_wsel,
    input  logic [DW-1:0]  bus_wdata,
    input  logic [SW-1:0]  bus_wstrb,
    input  logic [IXW-1:0] rd_idx,
    output logic [DW-1:0]  rd_data,
    output logic           wr_ready,
    output logic           irq
);

    localparam int NBW = $clog2(SW + 1);

    phase_e phase;
    logic   fin_req;

    logic   start_cmd;
    logic   proc_cmd;
    logic   data_ok;
    logic [NBW-1:0] nbytes;

    logic   buf_full;
    logic   buf_tail;
    logic   buf_fit;
    logic [BLK_WORDS*WORD_W-1:0] blk_word;
    logic [LEN_W-1:0] len_bits;
    buf_op_e op;

    logic   core_busy;
    logic   core_done;
    logic   core_load;
    logic [HASH_WORDS*WORD_W-1:0] core_hash;

    // Command decoding: start has priority over process.
    assign start_cmd = bus_wr && !bus_wsel && bus_wdata[0];
    assign proc_cmd  = bus_wr && !bus_wsel && bus_wdata[1] && !bus_wdata[0];
    assign nbytes    = NBW'($countones(bus_wstrb));

    assign wr_ready  = (phase == PH_DATA) && !fin_req && !buf_full && !buf_tail;
    assign data_ok   = bus_wr && bus_wsel && wr_ready && (nbytes != '0);

    always_comb begin
        op = BOP_NONE;
        if (!start_cmd && !core_busy) begin
            case (phase)
                PH_DATA: begin
                    if (buf_full && !buf_tail) begin
                        op = BOP_SEND;
                    end else if (fin_req) begin
                        op = BOP_MARK;
                    end
                end
                PH_LEN: begin
                    op = buf_fit ? BOP_SEND_LEN : BOP_SEND;
                end
                default: op = BOP_NONE;
            endcase
        end
    end

    assign core_load = (op == BOP_SEND) || (op == BOP_SEND_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            fin_req <= 1'b0;
            irq     <= 1'b0;
        end else if (start_cmd) begin
            phase   <= PH_DATA;
            fin_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (phase == PH_DATA && proc_cmd) begin
                fin_req <= 1'b1;
            end
            if (op == BOP_MARK) begin
                phase <= PH_LEN;
            end
            if (op == BOP_SEND_LEN) begin
                phase <= PH_LAST;
            end
            if (phase == PH_LAST && core_done) begin
                irq     <= 1'b1;
                phase   <= PH_IDLE;
                fin_req <= 1'b0;
            end
        end
    end

    sha256_len_ctr #(
        .LW  (LEN_W),
        .NBW (NBW)
    ) len_ctr_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_cmd),
        .add_en    (data_ok),
        .add_bytes (nbytes),
        .len_bits  (len_bits)
    );

    sha256_msg_buf #(
        .NWORDS (BLK_WORDS),
        .WW     (DW),
        .LW     (LEN_W),
        .BPW    (SW),
        .NBW    (NBW)
    ) msg_buf_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_cmd),
        .wr_en     (data_ok),
        .wr_data   (bus_wdata),
        .wr_nbytes (nbytes),
        .op        (op),
        .len_bits  (len_bits),
        .full      (buf_full),
        .tail      (buf_tail),
        .fit_len   (buf_fit),
        .blk_out   (blk_word)
    );

    sha256_round_core #(
        .NWORDS  (BLK_WORDS),
        .NROUNDS (ROUNDS),
        .NHASH   (HASH_WORDS)
    ) core_i (
        .clk  (clk),
        .rst  (rst),
        .init (start_cmd),
        .load (core_load),
        .blk  (blk_word),
        .busy (core_busy),
        .done (core_done),
        .hash (core_hash)
    );

    assign rd_data = core_hash[(HASH_WORDS-1-int'(rd_idx))*DW +: DW];

endmodule

// File: rtl/sha256_autolen_chk.sv
module sha256_autolen_chk #(
    parameter int HW = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic          wr_ready,
    input logic          start_cmd,
    input logic          core_load,
    input logic          core_done,
    input logic          buf_full,
    input logic [HW-1:0] core_hash
);

    logic [7:0] lat;
    logic       counting;

    always_ff @(posedge clk) begin
        if (rst || start_cmd) begin
            lat      <= '0;
            counting <= 1'b0;
        end else if (core_load) begin
            lat      <= '0;
            counting <= 1'b1;
        end else if (counting) begin
            lat <= lat + 8'd1;
            if (core_done) begin
                counting <= 1'b0;
            end
        end
    end

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !start_cmd) |=> irq);

    p_digest_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !start_cmd) |=> $stable(core_hash));

    p_irq_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(core_done));

    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> (!irq && wr_ready));

    p_closed_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> !wr_ready);

    p_full_stalls_r8: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !wr_ready);

    p_block_latency_r8: assert property (@(posedge clk) disable iff (rst)
        core_done |-> (counting && lat == 8'd65));

endmodule

bind sha256_autolen sha256_autolen_chk #(.HW(256)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .wr_ready  (wr_ready),
    .start_cmd (start_cmd),
    .core_load (core_load),
    .core_done (core_done),
    .buf_full  (buf_full),
    .core_hash (core_hash)
);

// File: tb/sha256_autolen_tb_top.sv
`timescale 1ns/1ps
module sha256_autolen_tb_top;

    logic        clk;
    logic        rst;
    logic        bus_wr;
    logic        bus_wsel;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wstrb;
    logic [2:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wr_ready;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] mbuf [0:255];

    localparam logic [255:0] DG_ABC   = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] DG_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    localparam logic [255:0] DG_56    = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
    localparam logic [255:0] DG_INIT  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

    localparam logic [31:0] RK [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    sha256_autolen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_wsel  (bus_wsel),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .wr_ready  (wr_ready),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_digest(input int n);
        logic [31:0] h [8];
        logic [31:0] w [64];
        logic [7:0]  pb [0:319];
        logic [31:0] a, b, c, d, e, f, g, hh, t1, t2;
        logic [63:0] bl;
        int tot;
        tot = ((n + 9 + 63) / 64) * 64;
        for (int i = 0; i < 320; i++) pb[i] = (i < n) ? mbuf[i] : 8'h00;
        pb[n] = 8'h80;
        bl = 64'(n) * 64'd8;
        for (int i = 0; i < 8; i++) pb[tot-1-i] = bl[8*i +: 8];
        for (int i = 0; i < 8; i++) h[i] = DG_INIT[255-32*i -: 32];
        for (int bk = 0; bk < tot / 64; bk++) begin
            for (int t = 0; t < 16; t++)
                w[t] = {pb[bk*64+4*t], pb[bk*64+4*t+1], pb[bk*64+4*t+2], pb[bk*64+4*t+3]};
            for (int t = 16; t < 64; t++)
                w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                     + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
            a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4]; f = h[5]; g = h[6]; hh = h[7];
            for (int t = 0; t < 64; t++) begin
                t1 = hh + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + RK[t] + w[t];
                t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
                hh = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
            end
            h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e; h[5] += f; h[6] += g; h[7] += hh;
        end
        return {h[0], h[1], h[2], h[3], h[4], h[5], h[6], h[7]};
    endfunction

    // ---------------- helpers ----------------
    task automatic check256(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check1(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle_bus();
        bus_wr = 1'b0; bus_wsel = 1'b0; bus_wdata = '0; bus_wstrb = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; idle_bus(); rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd_write(input logic [31:0] val);
        bus_wr = 1'b1; bus_wsel = 1'b0; bus_wdata = val; bus_wstrb = 4'hF;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic raw_data(input logic [31:0] val, input logic [3:0] strb);
        bus_wr = 1'b1; bus_wsel = 1'b1; bus_wdata = val; bus_wstrb = strb;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic push_word(input logic [31:0] val, input logic [3:0] strb);
        int guard = 0;
        while (!wr_ready && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        raw_data(val, strb);
    endtask

    task automatic send_msg(input int n);
        for (int wi = 0; wi < (n + 3) / 4; wi++) begin
            logic [31:0] wv;
            int cnt;
            wv = '0;
            cnt = 0;
            for (int j = 0; j < 4; j++) begin
                if (4 * wi + j < n) begin
                    wv[31-8*j -: 8] = mbuf[4*wi+j];
                    cnt++;
                end
            end
            push_word(wv, 4'((4'hF << (4 - cnt)) & 4'hF));
        end
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            if (irq) begin
                ok = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic read_digest(output logic [255:0] dg);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.1;
            dg[255-32*i -: 32] = rd_data;
        end
        rd_idx = '0;
    endtask

    task automatic load_abc();
        mbuf[0] = 8'h61; mbuf[1] = 8'h62; mbuf[2] = 8'h63;
    endtask

    task automatic hash_and_check(input string req, input int n, input logic [255:0] exp);
        bit ok;
        logic [255:0] dg;
        cmd_write(32'h1);
        send_msg(n);
        cmd_write(32'h2);
        wait_irq(ok);
        check1({req, " irq raised"}, ok, 1'b1);
        read_digest(dg);
        check256(req, dg, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        logic [255:0] dg;
        check1("R1 irq after reset", irq, 1'b0);
        check1("R1 wr_ready after reset", wr_ready, 1'b0);
        read_digest(dg);
        check256("R1 initial digest words", dg, DG_INIT);
    endtask

    task automatic t_idle_ignores();
        logic [255:0] dg;
        // R3: data before any start; R9: process with nothing open
        raw_data(32'hdeadbeef, 4'hF);
        raw_data(32'h01234567, 4'hF);
        cmd_write(32'h2);
        repeat (100) @(negedge clk);
        check1("R9 process while idle leaves irq low", irq, 1'b0);
        read_digest(dg);
        check256("R9 process while idle leaves digest at initial", dg, DG_INIT);
        load_abc();
        hash_and_check("R3 early data ignored, abc digest", 3, DG_ABC);
    endtask

    task automatic t_abc_and_order();
        bit ok;
        logic [255:0] dg;
        load_abc();
        cmd_write(32'h1);
        check1("R2 wr_ready after start", wr_ready, 1'b1);
        check1("R2 irq cleared by start", irq, 1'b0);
        send_msg(3);
        cmd_write(32'h2);
        check1("R9 wr_ready low after process", wr_ready, 1'b0);
        wait_irq(ok);
        check1("R6 irq for abc", ok, 1'b1);
        read_digest(dg);
        check256("R4 abc digest", dg, DG_ABC);
        rd_idx = 3'd0; #0.1;
        n_checks++;
        if (rd_data !== 32'hba7816bf) begin
            n_fail++;
            $display("FAIL R11: word 0 got %h expected %h", rd_data, 32'hba7816bf);
        end
        rd_idx = 3'd7; #0.1;
        n_checks++;
        if (rd_data !== 32'hf20015ad) begin
            n_fail++;
            $display("FAIL R11: word 7 got %h expected %h", rd_data, 32'hf20015ad);
        end
        rd_idx = '0;
    endtask

    task automatic t_hold_after_done();
        logic [255:0] dg;
        repeat (50) @(negedge clk);
        check1("R6 irq held", irq, 1'b1);
        check1("R9 wr_ready low after completion", wr_ready, 1'b0);
        raw_data(32'h11111111, 4'hF);
        cmd_write(32'h2);
        repeat (80) @(negedge clk);
        read_digest(dg);
        check256("R6 digest held, late writes ignored (R3)", dg, DG_ABC);
        check1("R6 irq still held", irq, 1'b1);
    endtask

    task automatic t_empty();
        hash_and_check("R7 empty message digest", 0, DG_EMPTY);
    endtask

    task automatic t_two_block_vector();
        string s;
        s = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
        for (int i = 0; i < 56; i++) mbuf[i] = s[i];
        hash_and_check("R5 56-byte vector needs extra block", 56, DG_56);
    endtask

    task automatic t_lengths();
        int lens [14] = '{1, 2, 3, 4, 5, 52, 55, 56, 63, 64, 65, 119, 120, 200};
        foreach (lens[k]) begin
            string tag;
            for (int i = 0; i < lens[k]; i++) mbuf[i] = 8'((i * 37 + lens[k] * 11 + 5) & 255);
            tag = $sformatf("R4/R5 length %0d bytes", lens[k]);
            hash_and_check(tag, lens[k], ref_digest(lens[k]));
        end
    endtask

    task automatic t_tail_ignored();
        bit ok;
        logic [255:0] dg;
        load_abc();
        cmd_write(32'h1);
        push_word(32'h61626300, 4'b1110);
        check1("R10 wr_ready low after short word", wr_ready, 1'b0);
        raw_data(32'h64656667, 4'hF);
        cmd_write(32'h2);
        wait_irq(ok);
        check1("R10 irq", ok, 1'b1);
        read_digest(dg);
        check256("R10 write after short word ignored", dg, DG_ABC);
    endtask

    task automatic t_restart();
        bit ok;
        logic [255:0] dg;
        cmd_write(32'h1);
        for (int i = 0; i < 20; i++) push_word(32'h5a5a0000 + 32'(i), 4'hF);
        cmd_write(32'h3);
        check1("R2 start wins over process", wr_ready, 1'b1);
        load_abc();
        send_msg(3);
        cmd_write(32'h2);
        wait_irq(ok);
        check1("R2 irq after restart", ok, 1'b1);
        read_digest(dg);
        check256("R2 restart discards earlier words", dg, DG_ABC);
    endtask

    task automatic t_stall();
        bit ok;
        logic [255:0] dg;
        for (int i = 0; i < 128; i++) mbuf[i] = 8'((i * 13 + 7) & 255);
        cmd_write(32'h1);
        for (int wi = 0; wi < 16; wi++)
            push_word({mbuf[4*wi], mbuf[4*wi+1], mbuf[4*wi+2], mbuf[4*wi+3]}, 4'hF);
        check1("R8 wr_ready low with full buffer", wr_ready, 1'b0);
        @(negedge clk);
        check1("R8 buffer freed after hand-off", wr_ready, 1'b1);
        for (int wi = 16; wi < 32; wi++)
            push_word({mbuf[4*wi], mbuf[4*wi+1], mbuf[4*wi+2], mbuf[4*wi+3]}, 4'hF);
        cmd_write(32'h2);
        wait_irq(ok);
        check1("R8 irq after streamed blocks", ok, 1'b1);
        read_digest(dg);
        check256("R8 streamed 128-byte digest", dg, ref_digest(128));
    endtask

    initial begin
        rst = 1'b1;
        idle_bus();
        rd_idx = '0;
        do_reset();
        t_reset_state();
        t_idle_ignores();
        t_abc_and_order();
        t_hold_after_done();
        t_empty();
        t_two_block_vector();
        t_lengths();
        t_tail_ignored();
        t_restart();
        t_stall();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R6): run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule